// File: doc/BRIEF.md
# Streaming Gradient Non-Maximum Suppression

This block thins a gradient field, one pixel per clock. Each incoming word packs a signed horizontal and a signed vertical gradient for one pixel, and the words arrive in raster order for an image `IMG_W` pixels wide. Two row delay chains and a 3x3 register window give every pixel its eight neighbours. The block estimates each neighbour's edge strength as the sum of absolute gradient components. It picks one of four direction sectors for the centre from the signs of its components and from which component is larger; no arctangent is computed. It then averages two adjacent neighbour strengths on each side of the centre along that direction. The centre strength is passed on only if it beats both averages. Otherwise a zero is passed on.

Both stream edges use valid/ready. A word is taken on a clock edge where `in_valid` and `in_ready` are both high. A result is handed over on an edge where `out_valid` and `out_ready` are both high. The block holds one result at a time, so `in_ready` drops only while a result waits unclaimed. While `out_valid` is high and `out_ready` is low, the result stays frozen. Borders are not masked: neighbour positions are fixed offsets in the stream and wrap across row ends. A downstream stage drops the edge rows and columns.

Top module: `nms_stage`

## Requirements
- R1: `in_data[17:9]` is the horizontal gradient gx and `in_data[8:0]` is the vertical gradient gy, both 9-bit two's complement.
- R2: A pixel's strength is |gx| + |gy|, saturated to 511, so a word with both components at -256 has strength 511.
- R3: The sector is chosen from the centre's components. Two flags are used: "same" means the sign bits of gx and gy are equal (zero counts as positive), and "steep" means |gy| > |gx|. Sector A is same and not steep, B is same and steep, C is not same and steep, and D is not same and not steep.
- R4: With rows above, at and below the centre written y-1, y, y+1, and columns written x-1, x, x+1, the two side values are taken as follows. A uses means of {(x+1,y-1),(x+1,y)} and {(x-1,y+1),(x,y+1)}. B uses {(x,y-1),(x+1,y-1)} and {(x,y+1),(x-1,y+1)}. C uses {(x,y-1),(x-1,y-1)} and {(x,y+1),(x+1,y+1)}. D uses {(x-1,y-1),(x-1,y)} and {(x+1,y+1),(x,y+1)}. Each mean is the 10-bit sum of the two strengths shifted right by one.
- R5: The result is the centre strength when it is strictly greater than both side means, and 0 otherwise. Ties are suppressed.
- R6: Counting accepted words from 0 after reset, accepting word n with n >= 2*IMG_W+2 produces the result for the centre at stream position n-IMG_W-1, valid from the next cycle. Neighbour (x+dx, y+dy) is stream position centre + dy*IMG_W + dx. The first 2*IMG_W+2 words produce no result.
- R7: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_mag` does not change.
- R8: While `rst_n` is low, `out_valid` is low and `in_ready` is high. After reset, the priming count of R6 starts again from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Block can take a word this cycle |
| in_data | input | 18 | Packed gradient pair {gx, gy} |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_mag | output | 9 | Kept centre strength, or 0 when suppressed |

## Verification
A window or delay-chain register that shifts at the wrong moment shifts every neighbour's stream offset. That shows up as wrong `out_mag` values on the first non-flat pixels after priming, within a row or two of the fault. A wrong priming count shows on `out_valid` at the 2*IMG_W+2 boundary. A wrong sector or pairing shows only for centres in that sector, so the stimulus mixes random gradients with flat fields (ties), isolated spikes and saturated extremes. Back-pressure faults show as a changed `out_mag` or a lost result in the cycle after a stall.

// File: rtl/nms_pkg.sv
package nms_pkg;

  localparam int COMP_W = 9;
  localparam int PIX_W  = 2 * COMP_W;
  localparam int MAG_W  = 9;
  localparam int MAG_MAX = (1 << MAG_W) - 1;

  typedef logic [PIX_W-1:0] pix_t;
  typedef logic [MAG_W-1:0] mag_t;

  // flat/steep by |gy| > |gx|, same/opposite by sign bits
  typedef enum logic [1:0] {
    SEC_FLAT_SAME  = 2'd0,
    SEC_STEEP_SAME = 2'd1,
    SEC_STEEP_OPP  = 2'd2,
    SEC_FLAT_OPP   = 2'd3
  } sector_e;

  function automatic logic [COMP_W:0] comp_abs(input logic [COMP_W-1:0] v);
    if (v[COMP_W-1]) comp_abs = {1'b0, ~v} + (COMP_W+1)'(1);
    else             comp_abs = {1'b0, v};
  endfunction

  function automatic mag_t approx_mag(input pix_t p);
    logic [COMP_W+1:0] s;
    s = {1'b0, comp_abs(p[PIX_W-1:COMP_W])} + {1'b0, comp_abs(p[COMP_W-1:0])};
    if (s > (COMP_W+2)'(MAG_MAX)) approx_mag = mag_t'(MAG_MAX);
    else                          approx_mag = s[MAG_W-1:0];
  endfunction

endpackage

// File: rtl/nms_line_delay.sv
module nms_line_delay #(
  parameter int WIDTH = 18,
  parameter int DEPTH = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [WIDTH-1:0] src;
    if (i == 0) begin : g_head
      assign src = din;
    end else begin : g_body
      assign src = stage_q[i-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        stage_q[i] <= '0;
      else if (shift_en) stage_q[i] <= src;
    end
  end

  assign dout = stage_q[DEPTH-1];

endmodule

// File: rtl/nms_sector_decode.sv
module nms_sector_decode
  import nms_pkg::*;
(
  input  pix_t    centre,
  output sector_e sector
);

  logic [COMP_W-1:0] gx, gy;
  logic [COMP_W:0]   ax, ay;
  logic              same_sign, steep;

  always_comb begin
    gx        = centre[PIX_W-1:COMP_W];
    gy        = centre[COMP_W-1:0];
    ax        = comp_abs(gx);
    ay        = comp_abs(gy);
    same_sign = (gx[COMP_W-1] == gy[COMP_W-1]);
    steep     = (ay > ax);
    unique case ({same_sign, steep})
      2'b10:   sector = SEC_FLAT_SAME;
      2'b11:   sector = SEC_STEEP_SAME;
      2'b01:   sector = SEC_STEEP_OPP;
      default: sector = SEC_FLAT_OPP;
    endcase
  end

endmodule

// File: rtl/nms_suppress.sv
module nms_suppress
  import nms_pkg::*;
(
  input  mag_t [8:0] nb_mag,   // index row*3+col, row 0 above, col 0 left
  input  sector_e    sector,
  output mag_t       result
);

  localparam int CTR = 4;

  logic [3:0]   ia1, ib1, ia2, ib2;
  logic [MAG_W:0] sum1, sum2;
  mag_t         side1, side2;

  always_comb begin
    unique case (sector)
      SEC_FLAT_SAME:  begin ia1 = 4'd2; ib1 = 4'd5; ia2 = 4'd6; ib2 = 4'd7; end
      SEC_STEEP_SAME: begin ia1 = 4'd1; ib1 = 4'd2; ia2 = 4'd7; ib2 = 4'd6; end
      SEC_STEEP_OPP:  begin ia1 = 4'd1; ib1 = 4'd0; ia2 = 4'd7; ib2 = 4'd8; end
      default:        begin ia1 = 4'd0; ib1 = 4'd3; ia2 = 4'd8; ib2 = 4'd7; end
    endcase
    sum1   = {1'b0, nb_mag[ia1]} + {1'b0, nb_mag[ib1]};
    sum2   = {1'b0, nb_mag[ia2]} + {1'b0, nb_mag[ib2]};
    side1  = sum1[MAG_W:1];
    side2  = sum2[MAG_W:1];
    if ((nb_mag[CTR] > side1) && (nb_mag[CTR] > side2)) result = nb_mag[CTR];
    else                                                result = '0;
  end

endmodule

// File: rtl/nms_stage.sv
module nms_stage
  import nms_pkg::*;
#(
  parameter int IMG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [MAG_W-1:0] out_mag
);

  localparam int LB_DEPTH = IMG_W - 3;
  localparam int PRIME    = 2 * IMG_W + 2;
  localparam int CNT_W    = $clog2(PRIME + 1);

  pix_t win_q [3][3];
  pix_t win_d [3][3];
  pix_t lb_out [2];
  mag_t [8:0] nb_mag;
  sector_e sec;
  mag_t    res;

  logic             take;
  logic             primed;
  logic [CNT_W-1:0] seen_q;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign primed   = (seen_q == CNT_W'(PRIME));

  // row 2 is the newest; rows 1 and 0 are fed through delay chains
  for (genvar r = 0; r < 3; r++) begin : g_row
    assign win_d[r][0] = win_q[r][1];
    assign win_d[r][1] = win_q[r][2];
    if (r == 2) begin : g_new
      assign win_d[r][2] = in_data;
    end else begin : g_old
      assign win_d[r][2] = lb_out[r];
    end
    for (genvar c = 0; c < 3; c++) begin : g_col
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    win_q[r][c] <= '0;
        else if (take) win_q[r][c] <= win_d[r][c];
      end
      assign nb_mag[r*3+c] = approx_mag(win_d[r][c]);
    end
  end

  for (genvar k = 0; k < 2; k++) begin : g_lb
    nms_line_delay #(.WIDTH(PIX_W), .DEPTH(LB_DEPTH)) u_lb (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (take),
      .din      (win_q[k+1][0]),
      .dout     (lb_out[k])
    );
  end

  nms_sector_decode u_sec (
    .centre (win_d[1][1]),
    .sector (sec)
  );

  nms_suppress u_sup (
    .nb_mag (nb_mag),
    .sector (sec),
    .result (res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q    <= '0;
      out_valid <= 1'b0;
      out_mag   <= '0;
    end else begin
      if (take && !primed) seen_q <= seen_q + CNT_W'(1);
      if (take) begin
        out_valid <= primed;
        if (primed) out_mag <= res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/nms_stage_chk.sv
module nms_stage_chk #(
  parameter int IMG_W = 16
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic [8:0] out_mag
);

  localparam int PRIME = 2 * IMG_W + 2;
  localparam int CW    = $clog2(PRIME + 2);

  logic [CW-1:0] accepted_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) accepted_q <= '0;
    else if (in_valid && in_ready && accepted_q <= CW'(PRIME))
      accepted_q <= accepted_q + CW'(1);
  end

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_mag)));

  a_r7_blocked_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r6_priming_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (accepted_q <= CW'(PRIME)) |-> !out_valid);

  a_r6_result_needs_take: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));

  a_r8_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> !out_valid);

endmodule

bind nms_stage nms_stage_chk #(.IMG_W(IMG_W)) u_nms_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_mag   (out_mag)
);

// File: tb/test_nms_stage.sv
module test_nms_stage;

  localparam int W     = 16;
  localparam int PRIME = 2 * W + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [17:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [8:0]  out_mag;

  always #10 clk = ~clk;

  nms_stage #(.IMG_W(W)) i_nms_stage (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
    .in_data (in_data), .out_valid (out_valid), .out_ready (out_ready),
    .out_mag (out_mag)
  );

  int n_checks = 0;
  int n_fail   = 0;
  logic [17:0] hist[$];
  int exp_q[$];
  string tag = "R8";

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int comp(logic [17:0] p, bit hi);
    int v;
    v = hi ? int'(p[17:9]) : int'(p[8:0]);
    if (v >= 256) v -= 512;
    return v;
  endfunction

  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic int rmag(logic [17:0] p);
    int s;
    s = iabs(comp(p, 1'b1)) + iabs(comp(p, 1'b0));
    return (s > 511) ? 511 : s;
  endfunction

  function automatic int ref_result(int ctr);
    int m [3][3];
    int gx, gy, s1, s2;
    bit same, steep;
    for (int r = 0; r < 3; r++)
      for (int c = 0; c < 3; c++)
        m[r][c] = rmag(hist[ctr + (r - 1) * W + (c - 1)]);
    gx = comp(hist[ctr], 1'b1);
    gy = comp(hist[ctr], 1'b0);
    same  = ((gx < 0) == (gy < 0));
    steep = (iabs(gy) > iabs(gx));
    if (same && !steep)      begin s1 = (m[0][2] + m[1][2]) / 2; s2 = (m[2][0] + m[2][1]) / 2; end
    else if (same && steep)  begin s1 = (m[0][1] + m[0][2]) / 2; s2 = (m[2][1] + m[2][0]) / 2; end
    else if (steep)          begin s1 = (m[0][1] + m[0][0]) / 2; s2 = (m[2][1] + m[2][2]) / 2; end
    else                     begin s1 = (m[0][0] + m[1][0]) / 2; s2 = (m[2][2] + m[2][1]) / 2; end
    return (m[1][1] > s1 && m[1][1] > s2) ? m[1][1] : 0;
  endfunction

  // one clock: compare outputs, drive, predict the coming edge
  task automatic step(bit v, logic [17:0] d, bit rdy);
    bit exp_ready;
    @(negedge clk);
    check(out_valid == (exp_q.size() > 0), "R6", "out_valid", int'(out_valid), int'(exp_q.size() > 0));
    if (out_valid && exp_q.size() > 0)
      check(int'(out_mag) == exp_q[0], tag, "out_mag", int'(out_mag), exp_q[0]);
    in_valid  = v;
    in_data   = d;
    out_ready = rdy;
    #1;
    exp_ready = (exp_q.size() == 0) || rdy;
    check(in_ready == exp_ready, "R7", "in_ready", int'(in_ready), int'(exp_ready));
    if (exp_q.size() > 0 && rdy) void'(exp_q.pop_front());
    if (v && exp_ready) begin
      hist.push_back(d);
      if (hist.size() - 1 >= PRIME) exp_q.push_back(ref_result(hist.size() - 1 - W - 1));
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    hist.delete(); exp_q.delete();
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R8", "out_valid in reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R8", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
  endtask

  function automatic logic [17:0] pack(int gx, int gy);
    return {9'(gx), 9'(gy)};
  endfunction

  task automatic finish_run();
    $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL R6 watchdog: actual %0d cycles expected completion", 150000);
    finish_run();
  end

  initial begin
    do_reset();
    // R5: flat field, every centre ties its side means
    tag = "R5";
    for (int i = 0; i < 80; i++) step(1'b1, pack(20, -7), 1'b1);
    // R8: reset mid-stream restarts priming
    do_reset();
    // R4: isolated spikes in a zero field
    tag = "R4";
    for (int i = 0; i < 140; i++)
      step(1'b1, (i % 7 == 3) ? pack(100 - i % 3 * 90, 30 + i % 5 * 20) : pack(0, 0), 1'b1);
    // R2: saturated extremes
    tag = "R2";
    for (int i = 0; i < 120; i++) begin
      int sel = $urandom_range(0, 3);
      step(1'b1, (sel == 0) ? pack(-256, -256) : (sel == 1) ? pack(255, -256) :
                 (sel == 2) ? pack(-1, 255) : pack(0, 0), 1'b1);
    end
    // R1 R3: random words, full throughput
    tag = "R1 R3";
    for (int i = 0; i < 400; i++) step(1'b1, 18'($urandom()), 1'b1);
    // R7: random offers and random back-pressure
    tag = "R7";
    for (int i = 0; i < 600; i++)
      step(($urandom_range(0, 3) != 0), 18'($urandom()), ($urandom_range(0, 2) != 0));
    for (int i = 0; i < 4; i++) step(1'b0, '0, 1'b1);
    finish_run();
  end

endmodule